// File: doc/BRIEF.md
# Power Stage Start-up and Fault Recovery Sequencer

This block decides, on every system clock, whether the switching power stage may run. It combines the enable pin and the software enable bit with three digital fault flags (input undervoltage, input overvoltage, over-temperature) and with a current-limit pulse that arrives with each switching-cycle marker. From these it walks the stage through a timed soft-start, full regulation, a fault hold and a timed hiccup off period after a run of current-limited cycles.

While soft-start runs, the block holds the synchronous-rectifier inhibit high so the stage can start into a pre-charged output. Power-good is raised only once soft-start has finished and the stage is regulating. Every restart, whether after a fault, after a disable or after a hiccup, passes through a full soft-start again. The soft-start and off intervals are given in microseconds and converted to clock counts from a clock-frequency parameter. The comparators and the reference ramp sit outside the block; it only times and gates them.

Top module: `pwr_seq_top`

## Requirements
- R1: After LIM_RUN (default 16) consecutive switching cycles that each carry a current-limit pulse, the next clock drops stageOn and raises hiccupOn; hiccupOn stays high for exactly OFF_CYC clocks (CLK_MHZ*OFF_US), after which soft-start begins again with no action from outside.
- R2: A switching-cycle marker without a current-limit pulse clears the consecutive count, so 15 limited cycles, one clean cycle and 15 more limited cycles cause no hiccup.
- R3: srInhibit is high exactly while soft-start runs, and never while pGood is high or while stageOn is low.
- R4: With both enables high and no fault, stageOn and srInhibit rise on the next clock edge, and soft-start lasts exactly SS_CYC clocks (CLK_MHZ*SS_US), after which pGood rises and srInhibit falls on the same edge.
- R5: pGood is high only when both enables are high and soft-start has completed.
- R6: dischOn is high exactly when dischEn is high and the output is disabled, meaning runPin low or runSw low; it follows these inputs without a clock delay.
- R7: Any of uvFault, ovFault or otFault being high stops switching (stageOn and pGood low) from the next clock edge, and holds it stopped while the flag stays high, including when a start is requested.
- R8: When all faults clear, the stage restarts through soft-start (srInhibit high, pGood low), never directly at full regulation.
- R9: statUv, statOv and statOt each report their own fault flag, registered one clock after the flag.
- R10: During and right after reset, stageOn, srInhibit, pGood, hiccupOn and the three status bits are low.
- R11: Dropping either enable stops the stage on the next clock edge from any state, including in the middle of a hiccup off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runPin | input | 1 | Enable pin level |
| runSw | input | 1 | Software enable bit |
| dischEn | input | 1 | Output-discharge enable bit |
| uvFault | input | 1 | Input undervoltage flag |
| ovFault | input | 1 | Input overvoltage flag |
| otFault | input | 1 | Over-temperature flag |
| cycEnd | input | 1 | One-clock marker at the end of each switching cycle |
| limHit | input | 1 | Current limit reached in the cycle marked by cycEnd |
| stageOn | output | 1 | Power stage may switch; low means tri-stated |
| srInhibit | output | 1 | Synchronous rectifier inhibited |
| pGood | output | 1 | Output is regulating after soft-start |
| hiccupOn | output | 1 | Timed off period after repeated current limit |
| dischOn | output | 1 | Output-discharge switch closed |
| statUv | output | 1 | Undervoltage status bit |
| statOv | output | 1 | Overvoltage status bit |
| statOt | output | 1 | Over-temperature status bit |

## Verification
The properties assume that the fault flags arrive already filtered and synchronous to the clock, and that limHit is only meaningful in a clock where cycEnd is high, so a hiccup can only begin after a cycle marker with a limit pulse. The stimulus changes every input just after a rising edge and raises limHit only together with cycEnd. The intervals are shortened by setting the clock parameter to one cycle per microsecond, which keeps the full soft-start and off periods short enough to be walked cycle by cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SOFT,
    ST_RUN,
    ST_FAULT,
    ST_HICCUP
  } seqState_t;

  // Strobes from the sequencing control to the timing datapath.
  typedef struct packed {
    logic loadSs;   // start the soft-start interval
    logic loadOff;  // start the hiccup off interval
    logic countEn;  // stage switching: count current-limit runs
  } seqStrobe_t;

endpackage

// File: rtl/seq_dp.sv
module seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int SS_CYC  = 150,
  parameter int OFF_CYC = 1700,
  parameter int LIM_RUN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       cycEnd,
  input  logic       limHit,
  input  logic       uvFault,
  input  logic       ovFault,
  input  logic       otFault,
  output logic       timerZero,
  output logic       limTrip,
  output logic       statUv,
  output logic       statOv,
  output logic       statOt
);

  localparam int MAX_CYC = (SS_CYC > OFF_CYC) ? SS_CYC : OFF_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam int CW      = $clog2(LIM_RUN + 1);

  logic [TW-1:0] timer;
  logic [CW-1:0] limCnt;

  // Shared interval timer: loaded at the entry edge, counts down to zero.
  always_ff @(posedge clk) begin
    if (!rstN)                timer <= '0;
    else if (strobe.loadSs)   timer <= TW'(SS_CYC - 1);
    else if (strobe.loadOff)  timer <= TW'(OFF_CYC - 1);
    else if (timer != '0)     timer <= timer - 1'b1;
  end

  assign timerZero = (timer == '0);

  assign limTrip = strobe.countEn & cycEnd & limHit &
                   (limCnt == CW'(LIM_RUN - 1));

  // Consecutive current-limit counter.
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.countEn || limTrip) limCnt <= '0;
    else if (cycEnd)                          limCnt <= limHit ? limCnt + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statUv <= 1'b0;
      statOv <= 1'b0;
      statOt <= 1'b0;
    end else begin
      statUv <= uvFault;
      statOv <= ovFault;
      statOt <= otFault;
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       fault,
  input  logic       timerZero,
  input  logic       limTrip,
  output seqStrobe_t strobe,
  output logic       stageOn,
  output logic       srInhibit,
  output logic       pGood,
  output logic       hiccupOn
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:    if (enable && !fault) nextState = ST_SOFT;
      ST_SOFT: begin
        if (!enable)        nextState = ST_OFF;
        else if (fault)     nextState = ST_FAULT;
        else if (limTrip)   nextState = ST_HICCUP;
        else if (timerZero) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (!enable)        nextState = ST_OFF;
        else if (fault)     nextState = ST_FAULT;
        else if (limTrip)   nextState = ST_HICCUP;
      end
      ST_FAULT: begin
        if (!enable)        nextState = ST_OFF;
        else if (!fault)    nextState = ST_SOFT;
      end
      ST_HICCUP: begin
        if (!enable)        nextState = ST_OFF;
        else if (timerZero) nextState = fault ? ST_FAULT : ST_SOFT;
      end
      default:              nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  assign strobe.loadSs  = (nextState == ST_SOFT)   && (state != ST_SOFT);
  assign strobe.loadOff = (nextState == ST_HICCUP) && (state != ST_HICCUP);
  assign strobe.countEn = (state == ST_SOFT) || (state == ST_RUN);

  assign stageOn   = (state == ST_SOFT) || (state == ST_RUN);
  assign srInhibit = (state == ST_SOFT);
  assign pGood     = (state == ST_RUN);
  assign hiccupOn  = (state == ST_HICCUP);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int CLK_MHZ = 24,
  parameter int SS_US   = 150,
  parameter int OFF_US  = 1700,
  parameter int LIM_RUN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic runPin,
  input  logic runSw,
  input  logic dischEn,
  input  logic uvFault,
  input  logic ovFault,
  input  logic otFault,
  input  logic cycEnd,
  input  logic limHit,
  output logic stageOn,
  output logic srInhibit,
  output logic pGood,
  output logic hiccupOn,
  output logic dischOn,
  output logic statUv,
  output logic statOv,
  output logic statOt
);

  localparam int SS_CYC  = CLK_MHZ * SS_US;
  localparam int OFF_CYC = CLK_MHZ * OFF_US;

  seqStrobe_t strobe;
  logic timerZero, limTrip;
  logic enable, fault;

  assign enable  = runPin & runSw;
  assign fault   = uvFault | ovFault | otFault;
  assign dischOn = dischEn & ~enable;

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .fault     (fault),
    .timerZero (timerZero),
    .limTrip   (limTrip),
    .strobe    (strobe),
    .stageOn   (stageOn),
    .srInhibit (srInhibit),
    .pGood     (pGood),
    .hiccupOn  (hiccupOn)
  );

  seq_dp #(
    .SS_CYC  (SS_CYC),
    .OFF_CYC (OFF_CYC),
    .LIM_RUN (LIM_RUN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cycEnd    (cycEnd),
    .limHit    (limHit),
    .uvFault   (uvFault),
    .ovFault   (ovFault),
    .otFault   (otFault),
    .timerZero (timerZero),
    .limTrip   (limTrip),
    .statUv    (statUv),
    .statOv    (statOv),
    .statOt    (statOt)
  );

endmodule

// File: rtl/seq_chk.sv
module seq_chk (
  input logic clk,
  input logic rstN,
  input logic runPin,
  input logic runSw,
  input logic uvFault,
  input logic ovFault,
  input logic otFault,
  input logic cycEnd,
  input logic limHit,
  input logic stageOn,
  input logic srInhibit,
  input logic pGood,
  input logic hiccupOn,
  input logic dischOn,
  input logic statUv
);

  AST_HICCUP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiccupOn) |-> $past(cycEnd && limHit)); // R1

  AST_SR_INH_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    srInhibit |-> (stageOn && !pGood)); // R3

  AST_PGOOD_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    pGood |-> $past(runPin && runSw)); // R5

  AST_RUN_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pGood) |-> $past(srInhibit)); // R8

  AST_DISCH_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    dischOn |=> !stageOn); // R6

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (uvFault || ovFault || otFault) |=> (!stageOn && !pGood)); // R7

  AST_UV_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(uvFault) |=> (statUv == $past(uvFault))); // R9

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !(runPin && runSw) |=> (!stageOn && !hiccupOn)); // R11

endmodule

bind pwr_seq_top seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .runPin    (runPin),
  .runSw     (runSw),
  .uvFault   (uvFault),
  .ovFault   (ovFault),
  .otFault   (otFault),
  .cycEnd    (cycEnd),
  .limHit    (limHit),
  .stageOn   (stageOn),
  .srInhibit (srInhibit),
  .pGood     (pGood),
  .hiccupOn  (hiccupOn),
  .dischOn   (dischOn),
  .statUv    (statUv)
);

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int SS_CYC     = 150;
  localparam int OFF_CYC    = 1700;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN, runPin, runSw, dischEn, uvFault, ovFault, otFault, cycEnd, limHit;
  logic stageOn, srInhibit, pGood, hiccupOn, dischOn, statUv, statOv, statOt;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit finished   = 1'b0;

  // Vector fields: [7]runPin [6]runSw [5]dischEn [4]uv [3]ov [2]ot [1]expected dischOn
  localparam logic [7:0] VEC [8] = '{
    8'b11100000, 8'b01100010, 8'b10110010, 8'b11001000,
    8'b00100110, 8'b11111100, 8'b00000000, 8'b10001100
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_top #(.CLK_MHZ(1), .SS_US(SS_CYC), .OFF_US(OFF_CYC), .LIM_RUN(16)) u0 (
    .clk(clk), .rstN(rstN), .runPin(runPin), .runSw(runSw), .dischEn(dischEn),
    .uvFault(uvFault), .ovFault(ovFault), .otFault(otFault),
    .cycEnd(cycEnd), .limHit(limHit),
    .stageOn(stageOn), .srInhibit(srInhibit), .pGood(pGood), .hiccupOn(hiccupOn),
    .dischOn(dischOn), .statUv(statUv), .statOv(statOv), .statOt(statOt)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic limCycles(input int n, input logic hit);
    cycEnd = 1'b1;
    limHit = hit;
    step(n);
    cycEnd = 1'b0;
    limHit = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    rstN = 1'b0; runPin = 1'b0; runSw = 1'b0; dischEn = 1'b0;
    uvFault = 1'b0; ovFault = 1'b0; otFault = 1'b0; cycEnd = 1'b0; limHit = 1'b0;
    step(3);
    // R10 reset state
    chk("R10 stageOn", stageOn, 1'b0);
    chk("R10 srInhibit", srInhibit, 1'b0);
    chk("R10 pGood", pGood, 1'b0);
    chk("R10 hiccupOn", hiccupOn, 1'b0);
    chk("R10 status", statUv | statOv | statOt, 1'b0);
    rstN = 1'b1;
    step(1);
    chk("R10 stageOn after release", stageOn, 1'b0);

    // Table walk: discharge switch (R6) and status bits (R9)
    foreach (VEC[k]) begin
      {runPin, runSw, dischEn, uvFault, ovFault, otFault} = VEC[k][7:2];
      #1;
      chk("R6 dischOn", dischOn, VEC[k][1]);
      step(1);
      chk("R9 statUv", statUv, VEC[k][4]);
      chk("R9 statOv", statOv, VEC[k][3]);
      chk("R9 statOt", statOt, VEC[k][2]);
    end

    // Fresh start
    {runPin, runSw, dischEn, uvFault, ovFault, otFault} = 6'b0;
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);

    // R7: start requested while undervoltage present
    uvFault = 1'b1; runPin = 1'b1; runSw = 1'b1;
    step(5);
    chk("R7 held off by uv", stageOn, 1'b0);
    uvFault = 1'b0;
    step(1);
    // R4 / R3 soft-start entry
    chk("R4 stageOn rises", stageOn, 1'b1);
    chk("R3 srInhibit in soft-start", srInhibit, 1'b1);
    chk("R5 no pGood in soft-start", pGood, 1'b0);
    step(SS_CYC - 1);
    chk("R4 pGood not yet", pGood, 1'b0);
    chk("R3 srInhibit still high", srInhibit, 1'b1);
    step(1);
    chk("R4 pGood after soft-start", pGood, 1'b1);
    chk("R3 srInhibit released", srInhibit, 1'b0);

    // R2: interrupted run of limit cycles
    limCycles(15, 1'b1);
    limCycles(1, 1'b0);
    limCycles(15, 1'b1);
    chk("R2 no hiccup after broken run", hiccupOn, 1'b0);
    chk("R2 still regulating", pGood, 1'b1);

    // R1: a full run of 16
    limCycles(1, 1'b0);
    limCycles(15, 1'b1);
    chk("R1 no hiccup at 15", hiccupOn, 1'b0);
    limCycles(1, 1'b1);
    chk("R1 hiccup at 16", hiccupOn, 1'b1);
    chk("R1 stage tri-stated", stageOn, 1'b0);
    chk("R5 pGood dropped", pGood, 1'b0);
    step(OFF_CYC - 1);
    chk("R1 hiccup still timing", hiccupOn, 1'b1);
    step(1);
    chk("R1 hiccup ended", hiccupOn, 1'b0);
    chk("R1 soft-start rerun", srInhibit, 1'b1);

    // R7 / R8: over-temperature in regulation
    step(SS_CYC);
    chk("R4 back in regulation", pGood, 1'b1);
    otFault = 1'b1;
    step(1);
    chk("R7 stage stops on ot", stageOn, 1'b0);
    chk("R7 pGood low on ot", pGood, 1'b0);
    chk("R9 statOt reports", statOt, 1'b1);
    step(10);
    chk("R7 stays off while ot", stageOn, 1'b0);
    otFault = 1'b0;
    step(1);
    chk("R8 restart through soft-start", srInhibit, 1'b1);
    chk("R8 no direct pGood", pGood, 1'b0);

    // R11: hiccup reached from soft-start, then disable mid off-time
    limCycles(16, 1'b1);
    chk("R1 hiccup from soft-start", hiccupOn, 1'b1);
    step(20);
    runPin = 1'b0;
    dischEn = 1'b1;
    #1;
    chk("R6 discharge on pin low", dischOn, 1'b1);
    step(1);
    chk("R11 hiccup aborted by disable", hiccupOn, 1'b0);
    chk("R11 stage off", stageOn, 1'b0);
    runPin = 1'b1;
    #1;
    chk("R6 discharge off when enabled", dischOn, 1'b0);
    step(1);
    chk("R11 restart after re-enable", srInhibit, 1'b1);
    runSw = 1'b0;
    step(1);
    chk("R11 software disable stops stage", stageOn, 1'b0);

    summary();
  end

endmodule